// File: doc/BRIEF.md
# Calendar Real-Time Clock with Snapshot Read

This block keeps wall-clock time and date as a chain of counters: seconds, minutes, hours, day of week, day of month, month and two-digit year. It advances by one second on each rising edge of a slow tick input. That input comes from another clock domain, so it passes through a synchronizer first. Leap years are handled for February.

A host reaches the counters through a small synchronous register port. When the host reads the seconds register, every other field is copied into a shadow set at the same moment. Later reads of the minute, hour or date registers return that frozen copy, so the host sees one coherent time even if a second boundary passes between its reads. Every read returns its data one cycle after the request. Time registers can only be written straight after an unlock write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, with day of week 1, day of month 1, month 1 and year 0.
- R2: A read request (`req_i`=1, `we_i`=0) is answered by `ready_o` high for exactly one cycle, on the cycle after the request, with `rdata_o` valid in that cycle. `ready_o` never rises in the request cycle or for a write.
- R3: Address map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 unlock. A read of address 0 returns the live seconds value and captures all fields together. Reads of addresses 1 to 6 return the captured values, which later ticks leave unchanged until the next read of address 0.
- R4: A write to addresses 0 to 6 takes effect only if the immediately preceding write was to address 7. Any data value written to address 7 unlocks. A write to addresses 0 to 6 that is not preceded by an unlock leaves the time unchanged.
- R5: An unlock is consumed by one time-register write, so a second write without a new unlock is ignored.
- R6: Each tick increments seconds. Seconds 59 wraps to 0 and carries into minutes, and minutes 59 wraps to 0 and carries into hours.
- R7: Hours 23 wraps to 0 and advances both day of week and day of month. Day of week counts 1 to 7 and wraps from 7 to 1.
- R8: Day of month wraps to 1 past the length of the month (30 for months 4, 6, 9 and 11, and 31 for the other months except 2) and carries into month. Month 12 wraps to 1 and carries into year. Year 99 wraps to 0.
- R9: February (month 2) has 29 days when the year is divisible by 4, year 0 included, and 28 days otherwise.
- R10: If a tick is applied in the same cycle as a time write, the tick advances the newly written value, so the write is not lost.
- R11: A tick input held high for many cycles advances the time once. Each synchronized rising edge is one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Asynchronous one-second tick, rising-edge counted |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while ready_o is high |
| ready_o | output | 1 | Read response strobe, one cycle after the request |

## Verification
The bench walks carries through every level: the final second of a year, 30-day and 31-day month ends, and February in leap, non-leap and year-0 cases. A chain with a wrong day table or wrong leap test would show the wrong date after the tick. It checks that a minute read after a tick still returns the captured value, which a design without a shadow set would fail by returning the live minute. It also checks that a write with no unlock, or a second write on one unlock, changes nothing. It lines up a write with the synchronized tick edge, where a design that let one overwrite the other would lose either the write or the second. A tick held high for many cycles must count once.

// File: rtl/rtc_calendar_pkg.sv
`timescale 1ns/1ps
package rtc_calendar_pkg;

  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOW_W  = 3;
  localparam int DOM_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;

  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int DOW_MAX  = 7;
  localparam int MON_MAX  = 12;
  localparam int YEAR_MAX = 99;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DOM_W-1:0]  dom;
    logic [DOW_W-1:0]  dow;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  typedef enum logic [2:0] {
    A_SEC    = 3'd0,
    A_MIN    = 3'd1,
    A_HOUR   = 3'd2,
    A_DOW    = 3'd3,
    A_DOM    = 3'd4,
    A_MON    = 3'd5,
    A_YEAR   = 3'd6,
    A_UNLOCK = 3'd7
  } reg_addr_e;

  localparam cal_t CAL_RESET = '{year: '0, mon: MON_W'(1), dom: DOM_W'(1),
                                 dow: DOW_W'(1), hour: '0, min: '0, sec: '0};

  function automatic logic [DOM_W-1:0] days_in_month(input logic [MON_W-1:0] mon,
                                                     input logic leap);
    case (mon)
      MON_W'(2):  return leap ? DOM_W'(29) : DOM_W'(28);
      MON_W'(4),
      MON_W'(6),
      MON_W'(9),
      MON_W'(11): return DOM_W'(30);
      default:    return DOM_W'(31);
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_sync.sv
`timescale 1ns/1ps
module rtc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic pulse_o
);
  // STAGES flops for metastability, one more for edge detect
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], tick_i};
  end

  assign pulse_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/rtc_cal_chain.sv
`timescale 1ns/1ps
module rtc_cal_chain
  import rtc_calendar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  reg_addr_e         wr_field_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cal_t              cal_o
);
  cal_t cal_q, merged, nxt;
  logic [DOM_W-1:0] dim;
  logic leap;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:YEAR_W];

  // write first, then the tick advances the merged value
  always_comb begin
    merged = cal_q;
    if (wr_en_i) begin
      case (wr_field_i)
        A_SEC:   merged.sec  = wr_data_i[SEC_W-1:0];
        A_MIN:   merged.min  = wr_data_i[MIN_W-1:0];
        A_HOUR:  merged.hour = wr_data_i[HOUR_W-1:0];
        A_DOW:   merged.dow  = wr_data_i[DOW_W-1:0];
        A_DOM:   merged.dom  = wr_data_i[DOM_W-1:0];
        A_MON:   merged.mon  = wr_data_i[MON_W-1:0];
        A_YEAR:  merged.year = wr_data_i[YEAR_W-1:0];
        default: ;
      endcase
    end
  end

  assign leap = (merged.year[1:0] == 2'b00);
  assign dim  = days_in_month(merged.mon, leap);

  always_comb begin
    nxt = merged;
    if (tick_i) begin
      if (merged.sec >= SEC_W'(SEC_MAX)) begin
        nxt.sec = '0;
        if (merged.min >= MIN_W'(MIN_MAX)) begin
          nxt.min = '0;
          if (merged.hour >= HOUR_W'(HOUR_MAX)) begin
            nxt.hour = '0;
            nxt.dow  = (merged.dow >= DOW_W'(DOW_MAX)) ? DOW_W'(1) : merged.dow + 1'b1;
            if (merged.dom >= dim) begin
              nxt.dom = DOM_W'(1);
              if (merged.mon >= MON_W'(MON_MAX)) begin
                nxt.mon  = MON_W'(1);
                nxt.year = (merged.year >= YEAR_W'(YEAR_MAX)) ? '0 : merged.year + 1'b1;
              end else begin
                nxt.mon = merged.mon + 1'b1;
              end
            end else begin
              nxt.dom = merged.dom + 1'b1;
            end
          end else begin
            nxt.hour = merged.hour + 1'b1;
          end
        end else begin
          nxt.min = merged.min + 1'b1;
        end
      end else begin
        nxt.sec = merged.sec + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= CAL_RESET;
    else         cal_q <= nxt;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/rtc_bus_if.sv
`timescale 1ns/1ps
module rtc_bus_if
  import rtc_calendar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  reg_addr_e         addr_i,
  input  cal_t              cal_i,
  output logic              wr_en_o,
  output logic              unlock_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  logic              unlock_q, ready_q;
  logic [DATA_W-1:0] rdata_q;
  cal_t              shadow_q;
  logic [SEC_W-1:0]  unused_shadow_sec;

  assign unused_shadow_sec = shadow_q.sec;
  assign wr_en_o = req_i & we_i & (addr_i != A_UNLOCK) & unlock_q;

  // any write re-arms or consumes the unlock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            unlock_q <= 1'b0;
    else if (req_i && we_i) unlock_q <= (addr_i == A_UNLOCK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      rdata_q  <= '0;
      shadow_q <= CAL_RESET;
    end else begin
      ready_q <= req_i & ~we_i;
      if (req_i && !we_i) begin
        case (addr_i)
          A_SEC: begin
            rdata_q  <= DATA_W'(cal_i.sec);
            shadow_q <= cal_i;
          end
          A_MIN:   rdata_q <= DATA_W'(shadow_q.min);
          A_HOUR:  rdata_q <= DATA_W'(shadow_q.hour);
          A_DOW:   rdata_q <= DATA_W'(shadow_q.dow);
          A_DOM:   rdata_q <= DATA_W'(shadow_q.dom);
          A_MON:   rdata_q <= DATA_W'(shadow_q.mon);
          A_YEAR:  rdata_q <= DATA_W'(shadow_q.year);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign unlock_o = unlock_q;
  assign rdata_o  = rdata_q;
  assign ready_o  = ready_q;
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_calendar_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  cal_t      cal_q;
  logic      tick_p, wr_en, unlock_q;
  reg_addr_e addr;

  assign addr = reg_addr_e'(addr_i);

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pulse_o(tick_p)
  );

  rtc_cal_chain #(.DATA_W(DATA_W)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_p),
    .wr_en_i   (wr_en),
    .wr_field_i(addr),
    .wr_data_i (wdata_i),
    .cal_o     (cal_q)
  );

  rtc_bus_if #(.DATA_W(DATA_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr),
    .cal_i   (cal_q),
    .wr_en_o (wr_en),
    .unlock_o(unlock_q),
    .rdata_o (rdata_o),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk
  import rtc_calendar_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_i,
  input logic ready_o,
  input logic tick_p,
  input logic wr_en,
  input cal_t cal
);
  // R2
  read_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> ready_o);

  // R2
  ready_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(req_i && !we_i));

  // R11
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_p |=> !tick_p);

  // R6
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_p && !wr_en && cal.sec < SEC_W'(SEC_MAX)) |=> cal.sec == $past(cal.sec) + 1'b1);

  // R4
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en && !tick_p) |=> $stable(cal));

  // R7
  dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_p && !wr_en && cal.sec >= SEC_W'(SEC_MAX) && cal.min >= MIN_W'(MIN_MAX) &&
     cal.hour >= HOUR_W'(HOUR_MAX) && cal.dow >= DOW_W'(DOW_MAX)) |=> cal.dow == DOW_W'(1));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .ready_o(ready_o),
  .tick_p (tick_p),
  .wr_en  (wr_en),
  .cal    (cal_q)
);

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ready;
  logic       done = 1'b0;

  int    n_vec = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rtc_calendar dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .tick_i (tick),
    .req_i  (req),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .ready_o(ready)
  );

  // monitor: pop expected read data on every response
  always @(negedge clk) begin
    if (rst_n && ready) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected ready with data %0d, expected no response", rdata);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e[7:0]) begin
          n_bad++;
          $display("FAIL %s: got %0d expected %0d", t, rdata, e);
        end
      end
    end
  end

  task automatic read_reg(input logic [2:0] a, input int e, input string t);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    n_vec++;
    if (ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 (%s): ready got %0b expected 0 on second cycle", t, ready);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic set_field(input logic [2:0] a, input logic [7:0] d);
    write_reg(3'd7, 8'hA5);
    write_reg(a, d);
  endtask

  task automatic set_all(input int s, input int m, input int h, input int dw,
                         input int dm, input int mo, input int y);
    set_field(3'd0, 8'(s));
    set_field(3'd1, 8'(m));
    set_field(3'd2, 8'(h));
    set_field(3'd3, 8'(dw));
    set_field(3'd4, 8'(dm));
    set_field(3'd5, 8'(mo));
    set_field(3'd6, 8'(y));
  endtask

  task automatic check_all(input int s, input int m, input int h, input int dw,
                           input int dm, input int mo, input int y, input string t);
    read_reg(3'd0, s, {t, " sec"});
    read_reg(3'd1, m, {t, " min"});
    read_reg(3'd2, h, {t, " hour"});
    read_reg(3'd3, dw, {t, " dow"});
    read_reg(3'd4, dm, {t, " dom"});
    read_reg(3'd5, mo, {t, " mon"});
    read_reg(3'd6, y, {t, " year"});
  endtask

  task automatic do_tick(input int hold);
    tick = 1'b1;
    repeat (hold) @(negedge clk);
    tick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all(0, 0, 0, 1, 1, 1, 0, "R1");

    // R4 locked write dropped, unlocked write lands
    write_reg(3'd0, 8'd30);
    read_reg(3'd0, 0, "R4 locked write");
    write_reg(3'd7, 8'h00);
    write_reg(3'd0, 8'd30);
    read_reg(3'd0, 30, "R4 unlocked write");
    // R5 second write on same unlock dropped
    write_reg(3'd1, 8'd5);
    read_reg(3'd0, 30, "R5 sec");
    read_reg(3'd1, 0, "R5 second write dropped");

    // R3 shadow frozen across a tick, R6 sec carry
    set_all(59, 10, 5, 2, 3, 6, 20);
    read_reg(3'd0, 59, "R3 capture");
    do_tick(4);
    read_reg(3'd1, 10, "R3 shadow holds");
    read_reg(3'd0, 0, "R6 sec wrap");
    read_reg(3'd1, 11, "R6 min carry");
    read_reg(3'd2, 5, "R6 hour steady");

    // R6 minute carry into hour
    set_all(59, 59, 5, 2, 3, 6, 20);
    do_tick(4);
    check_all(0, 0, 6, 2, 3, 6, 20, "R6 hour carry");

    // R7 R8 full year rollover with dow wrap
    set_all(59, 59, 23, 7, 31, 12, 99);
    do_tick(4);
    check_all(0, 0, 0, 1, 1, 1, 0, "R7 R8 year rollover");

    // R8 30-day month end
    set_all(59, 59, 23, 3, 30, 4, 21);
    do_tick(4);
    check_all(0, 0, 0, 4, 1, 5, 21, "R8 30-day month");

    // R8 31-day month does not end at 30
    set_all(59, 59, 23, 4, 30, 1, 21);
    do_tick(4);
    check_all(0, 0, 0, 5, 31, 1, 21, "R8 31-day month");

    // R9 February
    set_all(59, 59, 23, 1, 28, 2, 23);
    do_tick(4);
    check_all(0, 0, 0, 2, 1, 3, 23, "R9 non-leap");
    set_all(59, 59, 23, 1, 28, 2, 24);
    do_tick(4);
    check_all(0, 0, 0, 2, 29, 2, 24, "R9 leap 29th");
    set_all(59, 59, 23, 1, 29, 2, 24);
    do_tick(4);
    check_all(0, 0, 0, 2, 1, 3, 24, "R9 leap end");
    set_all(59, 59, 23, 1, 28, 2, 0);
    do_tick(4);
    check_all(0, 0, 0, 2, 29, 2, 0, "R9 year 0 leap");

    // R10 write lands in the same cycle as the synchronized tick
    set_all(20, 0, 0, 1, 1, 1, 0);
    tick = 1'b1;
    @(negedge clk);
    write_reg(3'd7, 8'h3C);
    write_reg(3'd0, 8'd10);
    tick = 1'b0;
    repeat (4) @(negedge clk);
    read_reg(3'd0, 11, "R10 tick after write");

    // R11 long hold counts once
    do_tick(12);
    read_reg(3'd0, 12, "R11 held tick");

    repeat (3) @(negedge clk);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule